// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Port

This block is a synchronous serial port built on one clock pin and one shared data pin. It moves 8-bit words. As clock master it generates the serial clock itself at one of four rates taken from the system clock. As slave it takes the serial clock from the pad, passes it through a two-flop synchronizer and detects its edges. A direction bit picks whether the data pin drives or listens. Bit order and the clock idle level are configurable. Data is always sampled on a rising serial-clock edge and always shifted out on a falling edge, whatever the idle level.

Software loads a word and pulses `start` to begin or arm a transfer. After the eighth rising edge, a sticky completion flag rises and the received word appears on `rx_data`. While the port is disabled, both pins pass through the general-purpose data and direction values given on the `gpio_*` inputs. The serial logic then has no effect on the pins.

Top module: `hdx_serial_port`

## Requirements
- R1: With `en`=0, `sck_out`, `sck_oe`, `sdio_out` and `sdio_oe` equal `gpio_sck_out`, `gpio_sck_dir`, `gpio_sdio_out` and `gpio_sdio_dir`.
- R2: With `en`=1 and `master`=1, `sck_oe` is 1. During a transfer each half period of `sck_out` lasts 1, 2, 8 or 16 clock cycles for `rate_sel` = 0, 1, 2 or 3 (divide by 2, 4, 16 or 32).
- R3: As master, `sck_out` rests at `cpol` before and after a transfer. A transfer has exactly 16 clock transitions, and the clock ends at `cpol`.
- R4: Output data on `sdio_out` changes only after a falling serial-clock edge. With `cpol`=1, the data pin stays 1 after arming and the first bit appears at the first falling edge. With `cpol`=0, the first bit is present from arming.
- R5: Incoming bits are sampled from `sdio_in` on rising serial-clock edges. After 8 rising edges the word appears on `rx_data`.
- R6: With `lsbf`=0, the bit sent or received first is bit 7. With `lsbf`=1, it is bit 0.
- R7: With `en`=1 and `dir_tx`=0, `sdio_oe` is 0. With `en`=1 and `dir_tx`=1, `sdio_oe` is 1, and `sdio_out` is 1 while no transfer is in progress.
- R8: `done` rises only after the eighth rising edge and stays set until `flag_clr`. A `start` pulse during a transfer is ignored and does not change the word being sent.
- R9: With `en`=1 and `master`=0, `sck_oe` is 0. Transfers are clocked by `sck_in` through a two-flop synchronizer, and an armed transfer waits for the external clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Serial port enable; 0 hands the pins to GPIO |
| master | input | 1 | 1 = generate the serial clock, 0 = take it from `sck_in` |
| dir_tx | input | 1 | Data pin direction: 1 drive, 0 listen |
| lsbf | input | 1 | 1 = least significant bit first |
| cpol | input | 1 | Serial clock idle level |
| rate_sel | input | 2 | Master clock divider select |
| tx_data | input | 8 | Word to send, latched on start |
| start | input | 1 | Begin (master) or arm (slave) a transfer |
| flag_clr | input | 1 | Clears `done` |
| gpio_sck_out | input | 1 | GPIO output value for the clock pin |
| gpio_sck_dir | input | 1 | GPIO direction for the clock pin |
| gpio_sdio_out | input | 1 | GPIO output value for the data pin |
| gpio_sdio_dir | input | 1 | GPIO direction for the data pin |
| sck_in | input | 1 | Clock pad input |
| sdio_in | input | 1 | Data pad input |
| sck_out | output | 1 | Clock pad output value |
| sck_oe | output | 1 | Clock pad output enable |
| sdio_out | output | 1 | Data pad output value |
| sdio_oe | output | 1 | Data pad output enable |
| rx_data | output | 8 | Last received word |
| done | output | 1 | Sticky transfer-complete flag |

## Verification
Master transfers are run with both idle levels, both bit orders and all four rates. A bench-side receiver records `sdio_out` just before each rising clock and drives `sdio_in` after each falling clock. This separates an off-by-one in the first bit at each idle level, a reversed bit order and a wrong divider. Slave transfers use a slow external clock to show that output bits follow falling edges and that the data pin holds high until the first falling edge when `cpol`=1. Directed cases cover GPIO passthrough, a `start` pulse in the middle of a transfer and holding and clearing the flag. Seeded random words and settings fill in the rest.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  // Half period of the master serial clock, in system clock cycles.
  function automatic int unsigned half_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;   // divide by 2
      2'd1:    return 2;   // divide by 4
      2'd2:    return 8;   // divide by 16
      default: return 16;  // divide by 32
    endcase
  endfunction
endpackage

// File: rtl/hdx_master_clk.sv
module hdx_master_clk #(
  parameter int CW = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       cpol,
  input  logic [1:0] rate_sel,
  output logic       sck_lvl,
  output logic       rise_ev,
  output logic       fall_ev,
  output logic       idle
);
  import hdx_pkg::*;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;
  logic          run;
  logic          active;
  logic          tick;

  assign half_m1 = CW'(half_period(rate_sel) - 1);
  // Keep toggling after the last bit until the clock is back at idle.
  assign active  = go || (run && (sck_lvl != cpol));
  assign tick    = active && (cnt == half_m1);
  assign rise_ev = tick && !sck_lvl;
  assign fall_ev = tick && sck_lvl;
  assign idle    = !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sck_lvl <= 1'b0;
      run     <= 1'b0;
    end else begin
      run <= go || (active && !tick);
      if (!active) begin
        cnt     <= '0;
        sck_lvl <= cpol;
      end else if (tick) begin
        cnt     <= '0;
        sck_lvl <= ~sck_lvl;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/hdx_sck_sync.sv
module hdx_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise_ev,
  output logic fall_ev
);
  // STAGES synchronizer flops plus one history flop for edge detection.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign rise_ev = sh[STAGES-1] && !sh[STAGES];
  assign fall_ev = !sh[STAGES-1] && sh[STAGES];
endmodule

// File: rtl/hdx_shifter.sv
module hdx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          arm,
  input  logic          cpol,
  input  logic          lsbf,
  input  logic [DW-1:0] tx_data,
  input  logic          sdi,
  input  logic          rise_ev,
  input  logic          fall_ev,
  input  logic          flag_clr,
  output logic          busy,
  output logic          out_bit,
  output logic [DW-1:0] rx_data,
  output logic          done
);
  localparam int CNTW = $clog2(DW + 1);
  localparam int IW   = $clog2(DW);

  logic [DW-1:0]   tx_sr;
  logic [DW-1:0]   rx_sr;
  logic [DW-1:0]   rx_next;
  logic [CNTW-1:0] rcnt;
  logic [CNTW-1:0] fcnt;
  logic [CNTW-1:0] oidx;
  logic            last_rise;

  function automatic logic pick(input logic [DW-1:0] d, input logic [IW-1:0] k,
                                input logic lf);
    return lf ? d[k] : d[IW'(DW - 1) - k];
  endfunction

  assign rx_next   = lsbf ? {sdi, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], sdi};
  // Idle-high clock: first fall shows bit 0. Idle-low: bit 0 shown at arm.
  assign oidx      = cpol ? fcnt : fcnt + CNTW'(1);
  assign last_rise = busy && rise_ev && (rcnt == CNTW'(DW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      out_bit <= 1'b1;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_data <= '0;
      rcnt    <= '0;
      fcnt    <= '0;
      done    <= 1'b0;
    end else begin
      if (last_rise)     done <= 1'b1;
      else if (flag_clr) done <= 1'b0;

      if (!en) begin
        busy    <= 1'b0;
        out_bit <= 1'b1;
      end else if (arm) begin
        busy    <= 1'b1;
        tx_sr   <= tx_data;
        rcnt    <= '0;
        fcnt    <= '0;
        out_bit <= cpol ? 1'b1 : pick(tx_data, '0, lsbf);
      end else if (busy) begin
        if (fall_ev) begin
          fcnt <= fcnt + CNTW'(1);
          if (oidx < CNTW'(DW)) out_bit <= pick(tx_sr, oidx[IW-1:0], lsbf);
        end
        if (rise_ev) begin
          rx_sr <= rx_next;
          rcnt  <= rcnt + CNTW'(1);
          if (last_rise) begin
            busy    <= 1'b0;
            rx_data <= rx_next;
            out_bit <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdx_serial_port.sv
module hdx_serial_port #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          master,
  input  logic          dir_tx,
  input  logic          lsbf,
  input  logic          cpol,
  input  logic [1:0]    rate_sel,
  input  logic [DW-1:0] tx_data,
  input  logic          start,
  input  logic          flag_clr,
  input  logic          gpio_sck_out,
  input  logic          gpio_sck_dir,
  input  logic          gpio_sdio_out,
  input  logic          gpio_sdio_dir,
  input  logic          sck_in,
  input  logic          sdio_in,
  output logic          sck_out,
  output logic          sck_oe,
  output logic          sdio_out,
  output logic          sdio_oe,
  output logic [DW-1:0] rx_data,
  output logic          done
);
  localparam int CW = 5;

  logic busy, out_bit, arm;
  logic m_lvl, m_rise, m_fall, m_idle;
  logic s_rise, s_fall;
  logic rise_ev, fall_ev;

  hdx_master_clk #(.CW(CW)) u_mclk (
    .clk(clk), .rst(rst), .go(busy && master && en), .cpol(cpol),
    .rate_sel(rate_sel), .sck_lvl(m_lvl), .rise_ev(m_rise),
    .fall_ev(m_fall), .idle(m_idle)
  );

  hdx_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(sck_in), .rise_ev(s_rise), .fall_ev(s_fall)
  );

  assign rise_ev = master ? m_rise : s_rise;
  assign fall_ev = master ? m_fall : s_fall;
  assign arm     = start && en && !busy && (!master || m_idle);

  hdx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .en(en), .arm(arm), .cpol(cpol), .lsbf(lsbf),
    .tx_data(tx_data), .sdi(sdio_in), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .flag_clr(flag_clr), .busy(busy), .out_bit(out_bit),
    .rx_data(rx_data), .done(done)
  );

  always_comb begin
    if (en) begin
      sck_out  = m_lvl;
      sck_oe   = master;
      sdio_out = out_bit;
      sdio_oe  = dir_tx;
    end else begin
      sck_out  = gpio_sck_out;
      sck_oe   = gpio_sck_dir;
      sdio_out = gpio_sdio_out;
      sdio_oe  = gpio_sdio_dir;
    end
  end
endmodule

// File: rtl/hdx_serial_port_chk.sv
module hdx_serial_port_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic master,
  input logic dir_tx,
  input logic gpio_sck_out,
  input logic gpio_sck_dir,
  input logic gpio_sdio_out,
  input logic gpio_sdio_dir,
  input logic sck_out,
  input logic sck_oe,
  input logic sdio_out,
  input logic sdio_oe,
  input logic busy,
  input logic rise_ev,
  input logic fall_ev,
  input logic flag_clr,
  input logic done
);
  a_r1_gpio_passthru: assert property (@(posedge clk) disable iff (rst)
    !en |-> (sck_out == gpio_sck_out && sck_oe == gpio_sck_dir &&
             sdio_out == gpio_sdio_out && sdio_oe == gpio_sdio_dir));

  a_r2_master_drives_clk: assert property (@(posedge clk) disable iff (rst)
    (en && master) |-> sck_oe);

  a_r9_slave_clk_input: assert property (@(posedge clk) disable iff (rst)
    (en && !master) |-> !sck_oe);

  a_r7_listen_hiz: assert property (@(posedge clk) disable iff (rst)
    (en && !dir_tx) |-> !sdio_oe);

  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    (en && dir_tx && !busy) |-> sdio_out);

  a_r4_shift_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sdio_out) && en && $past(en) && busy && $past(busy)) |-> $past(fall_ev));

  a_r8_done_needs_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(rise_ev));

  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !flag_clr) |=> done);
endmodule

bind hdx_serial_port hdx_serial_port_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .master(master), .dir_tx(dir_tx),
  .gpio_sck_out(gpio_sck_out), .gpio_sck_dir(gpio_sck_dir),
  .gpio_sdio_out(gpio_sdio_out), .gpio_sdio_dir(gpio_sdio_dir),
  .sck_out(sck_out), .sck_oe(sck_oe), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
  .busy(busy), .rise_ev(rise_ev), .fall_ev(fall_ev), .flag_clr(flag_clr),
  .done(done)
);

// File: tb/hdx_serial_port_tb.sv
module hdx_serial_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, master = 0, dir_tx = 0, lsbf = 0, cpol = 0;
  logic [1:0] rate_sel = 0;
  logic [7:0] tx_data = 0;
  logic start = 0, flag_clr = 0;
  logic gpio_sck_out = 0, gpio_sck_dir = 0, gpio_sdio_out = 0, gpio_sdio_dir = 0;
  logic sck_in = 0, sdio_in = 0;
  logic sck_out, sck_oe, sdio_out, sdio_oe, done;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hdx_serial_port u_dut (
    .clk(clk), .rst(rst), .en(en), .master(master), .dir_tx(dir_tx),
    .lsbf(lsbf), .cpol(cpol), .rate_sel(rate_sel), .tx_data(tx_data),
    .start(start), .flag_clr(flag_clr), .gpio_sck_out(gpio_sck_out),
    .gpio_sck_dir(gpio_sck_dir), .gpio_sdio_out(gpio_sdio_out),
    .gpio_sdio_dir(gpio_sdio_dir), .sck_in(sck_in), .sdio_in(sdio_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe), .rx_data(rx_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic pick(input logic [7:0] w, input int k, input bit lf);
    return lf ? w[k] : w[7-k];
  endfunction

  function automatic int exp_half(input logic [1:0] rs);
    case (rs)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic clear_flag();
    repeat (4) @(negedge clk);
    chk(done === 1'b1, "R8", "flag held", done, 1);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    @(negedge clk);
    chk(done === 1'b0, "R8", "flag cleared", done, 0);
  endtask

  // Bench acts as the far end: records the data pin just before each rising
  // clock, and presents the next receive bit after each falling clock.
  task automatic master_xfer(input bit cp, input bit lf, input logic [1:0] rs,
                             input logic [7:0] txw, input logic [7:0] rxw,
                             input bit poke);
    int tog = 0, f = 0, r = 0, t2 = 0, half = 0, cyc = 0, settle = 0, bad = 0, idx;
    logic prev, last;
    en = 1; master = 1; dir_tx = 1; cpol = cp; lsbf = lf; rate_sel = rs;
    tx_data = txw; sdio_in = pick(rxw, 0, lf);
    repeat (3) @(negedge clk);
    chk(sck_out === cp, "R3", "idle level before transfer", sck_out, cp);
    chk(sck_oe === 1'b1, "R2", "master drives clock", sck_oe, 1);
    chk(sdio_oe === 1'b1 && sdio_out === 1'b1, "R7", "tx idle high", sdio_out, 1);
    start = 1;
    @(negedge clk);
    start = 0;
    prev = sck_out; last = sdio_out;
    while (cyc < 2000 && settle < 6) begin
      @(negedge clk);
      cyc++;
      start = (poke && tog == 4);
      if (poke && tog == 4) tx_data = ~txw;
      if (sck_out !== prev) begin
        tog++;
        if (tog == 2) t2 = cyc;
        if (tog == 3) half = cyc - t2;
        if (sck_out) begin
          if (r < 8 && last !== pick(txw, r, lf)) bad++;
          r++;
        end else begin
          f++;
          idx = cp ? f - 1 : f;
          if (idx < 8) sdio_in = pick(rxw, idx, lf);
        end
      end
      prev = sck_out; last = sdio_out;
      if (tog >= 16) settle++;
    end
    start = 0; tx_data = txw;
    chk(bad == 0, poke ? "R8" : "R6", "sent bit sequence (R4 order)", bad, 0);
    chk(rx_data === rxw, "R5", "received word", rx_data, rxw);
    chk(half == exp_half(rs), "R2", "half period", half, exp_half(rs));
    chk(tog == 16, "R3", "clock transitions", tog, 16);
    chk(sck_out === cp, "R3", "idle level after transfer", sck_out, cp);
    clear_flag();
  endtask

  // Bench is the clock master with half period h system cycles.
  task automatic slave_xfer(input bit cp, input bit lf, input int h,
                            input logic [7:0] txw, input logic [7:0] rxw);
    int f = 0, r = 0, bad = 0, idx;
    en = 1; master = 0; dir_tx = 1; cpol = cp; lsbf = lf; sck_in = cp;
    tx_data = txw; sdio_in = pick(rxw, 0, lf);
    repeat (6) @(negedge clk);
    chk(sck_oe === 1'b0, "R9", "slave clock is input", sck_oe, 0);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (8) @(negedge clk);
    chk(done === 1'b0, "R9", "armed transfer waits for clock", done, 0);
    if (cp) chk(sdio_out === 1'b1, "R4", "idle-high holds until first fall", sdio_out, 1);
    else    chk(sdio_out === pick(txw, 0, lf), "R4", "first bit at arm", sdio_out, pick(txw, 0, lf));
    for (int ph = 0; ph < 16; ph++) begin
      if (sck_in == 1'b0) begin
        if (sdio_out !== pick(txw, r, lf)) bad++;
        r++;
        sck_in = 1;
      end else begin
        sck_in = 0;
        f++;
        idx = cp ? f - 1 : f;
        if (idx < 8) sdio_in = pick(rxw, idx, lf);
      end
      repeat (h) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk(bad == 0, "R4", "slave output bits follow falls (R6 order)", bad, 0);
    chk(rx_data === rxw, "R9", "slave received word (R5)", rx_data, rxw);
    chk(done === 1'b1, "R8", "flag after 8 rises", done, 1);
    clear_flag();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(done === 1'b0, "R8", "reset flag", done, 0);
    chk(rx_data === 8'h00, "R5", "reset rx_data", rx_data, 0);

    // R1: disabled port mirrors GPIO controls
    for (int i = 0; i < 8; i++) begin
      gpio_sck_out = i[0]; gpio_sck_dir = i[1]; gpio_sdio_out = i[2];
      gpio_sdio_dir = ~i[0];
      @(negedge clk);
      chk(sck_out === gpio_sck_out && sck_oe === gpio_sck_dir &&
          sdio_out === gpio_sdio_out && sdio_oe === gpio_sdio_dir,
          "R1", "gpio passthrough", {sck_out, sck_oe, sdio_out, sdio_oe},
          {gpio_sck_out, gpio_sck_dir, gpio_sdio_out, gpio_sdio_dir});
    end

    // R7: direction bit controls the data pin
    en = 1; master = 1; dir_tx = 0;
    @(negedge clk);
    chk(sdio_oe === 1'b0, "R7", "listen is high-impedance", sdio_oe, 0);
    dir_tx = 1;
    @(negedge clk);
    chk(sdio_oe === 1'b1 && sdio_out === 1'b1, "R7", "drive idles high", sdio_out, 1);

    // Directed master transfers: both idle levels, both orders, all rates
    master_xfer(1, 0, 2'd0, 8'h5A, 8'hC3, 1);
    master_xfer(0, 1, 2'd3, 8'hA5, 8'h3C, 0);
    master_xfer(1, 1, 2'd1, 8'h01, 8'h80, 0);
    master_xfer(0, 0, 2'd2, 8'h80, 8'h01, 0);
    for (int i = 0; i < 8; i++) begin
      a = 8'($urandom); b = 8'($urandom);
      master_xfer(1'($urandom), 1'($urandom), 2'($urandom), a, b, 0);
    end

    // Directed slave transfers; first bit 0 to expose an early drive
    slave_xfer(1, 0, 5, 8'h5A, 8'h96);
    slave_xfer(0, 1, 7, 8'h6E, 8'h21);
    slave_xfer(1, 1, 6, 8'hF0, 8'h0F);
    for (int i = 0; i < 4; i++) begin
      a = 8'($urandom); b = 8'($urandom);
      slave_xfer(1'($urandom), 1'($urandom), 5 + int'($urandom % 6), a, b);
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule